// File: doc/BRIEF.md
# Programmable burst column address generator

This block produces the column address sequence for one memory burst. A controller pulses a start strobe with a starting column and a read/write flag. From the next clock on, the block presents one column address per cycle, with a valid flag and a flag that marks the final beat. It takes the burst length, the burst ordering and a single-beat-write option from the programmed mode fields. It copies them at the start strobe, so a mode change during a burst does not affect the burst in progress.

Finite bursts wrap inside the block of columns aligned to their length, and the upper column bits stay fixed. Sequential ordering counts upward within that block. Interleaved ordering combines the start column and the beat index with XOR. The full-page length counts upward through all columns until a stop strobe or a new start ends it. A new start is accepted on any cycle, including in the middle of a burst.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, and until the first start strobe, `colValid` and `lastBeat` are 0.
- R2: The length code on `modeLen` selects the number of beats: 3'b000 gives 1, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8, 3'b111 gives full page, and every other code gives 1. Beat 0 is presented in the cycle after the clock edge that samples `startStb`, and it equals `startCol`.
- R3: In sequential order (`modeInterleave`=0), beat k is (startCol + k) taken modulo the burst length in the low log2(length) bits. The remaining upper bits stay equal to those of `startCol`.
- R4: In interleaved order (`modeInterleave`=1) with a finite length, the low log2(length) bits of beat k are startCol XOR k. The upper bits stay fixed.
- R5: Full page always counts sequentially, whatever `modeInterleave` is. It wraps from 255 to 0, never raises `lastBeat`, and keeps running until a stop strobe or a new start.
- R6: `lastBeat` is 1 only on the final beat of a finite burst. In the cycle after that beat, `colValid` is 0 unless a new start was sampled.
- R7: A `stopStb` sampled without `startStb` ends any burst: `colValid` is 0 from the next cycle.
- R8: A start sampled at any time, including the cycle right after another start or together with `stopStb`, begins a new burst from its own `startCol` in the next cycle.
- R9: When `modeSingleWrite`=1, a write (`isWrite`=1) is one beat long whatever the length code. A read keeps the programmed length.
- R10: Mode fields and `isWrite` are sampled only at the start strobe. Changes to them during a burst leave its addresses and length unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startStb | input | 1 | Begin a burst at `startCol` |
| startCol | input | 8 | First column of the burst |
| isWrite | input | 1 | 1 for a write burst, 0 for a read |
| stopStb | input | 1 | End the current burst |
| modeLen | input | 3 | Burst length code |
| modeInterleave | input | 1 | 1 selects interleaved order |
| modeSingleWrite | input | 1 | 1 forces writes to one beat |
| colOut | output | 8 | Column address of the current beat |
| colValid | output | 1 | `colOut` carries a burst beat |
| lastBeat | output | 1 | Current beat is the final one of a finite burst |

## Verification
The bench targets the wrap points. A start column near the top of an aligned block exposes a design that carries into the upper bits, because its addresses leave the block. A full-page start near 255 exposes a design that stops or saturates at the top column instead of wrapping to 0.

It also targets the control corners. When starts arrive back to back, or a start coincides with a stop, a faulty design finishes the old burst or drops the new one. During every burst the bench scrambles the mode and direction inputs. A design that reads them live rather than latching them then changes length or order in mid-burst. Single-beat writes mixed with reads show whether the length override is wrongly applied to reads, or missing from writes.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  localparam int LEN_W = 3;
  localparam logic [LEN_W-1:0] LEN_FULL = 3'b111;

  // control -> datapath strobes
  typedef struct packed {
    logic load;   // capture a new burst
    logic step;   // advance to next beat
  } bcgStrobe_t;
endpackage

// File: rtl/bcg_datapath.sv
module bcg_datapath
  import bcg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  bcgStrobe_t       strb,
  input  logic [COL_W-1:0] startCol,
  input  logic             isWrite,
  input  logic [LEN_W-1:0] modeLen,
  input  logic             modeInterleave,
  input  logic             modeSingleWrite,
  output logic [COL_W-1:0] colOut,
  output logic             beatIsLast
);
  localparam int MAX_FIN_LOG = 3;  // longest finite burst is 2**3 beats

  logic [COL_W-1:0] baseQ, cntQ, maskQ;
  logic             ilQ, fullQ;

  logic             forceOne, fullD;
  logic [COL_W-1:0] maskD;

  always_comb begin
    forceOne = isWrite && modeSingleWrite;
    fullD    = (modeLen == LEN_FULL) && !forceOne;
    maskD    = '0;
    if (fullD) begin
      maskD = '1;
    end else if (!forceOne) begin
      for (int i = 1; i <= MAX_FIN_LOG; i++) begin
        if (modeLen == LEN_W'(i)) maskD = COL_W'((1 << i) - 1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
      cntQ  <= '0;
      maskQ <= '0;
      ilQ   <= 1'b0;
      fullQ <= 1'b0;
    end else if (strb.load) begin
      baseQ <= startCol;
      cntQ  <= '0;
      maskQ <= maskD;
      ilQ   <= modeInterleave && !fullD;
      fullQ <= fullD;
    end else if (strb.step) begin
      cntQ  <= cntQ + COL_W'(1);
    end
  end

  logic [COL_W-1:0] lowPart;
  always_comb begin
    lowPart    = ilQ ? (baseQ ^ cntQ) : (baseQ + cntQ);
    colOut     = (baseQ & ~maskQ) | (lowPart & maskQ);
    beatIsLast = !fullQ && (cntQ == maskQ);
  end

  AST_FIRST_BEAT_START: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> colOut == $past(startCol)); // R2

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> (colOut & ~maskQ) == ($past(colOut) & ~$past(maskQ))); // R3
endmodule

// File: rtl/bcg_ctrl.sv
module bcg_ctrl
  import bcg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startStb,
  input  logic       stopStb,
  input  logic       beatIsLast,
  output bcgStrobe_t strb,
  output logic       active
);
  logic activeQ;

  always_comb begin
    strb.load = startStb;
    strb.step = activeQ && !startStb && !stopStb && !beatIsLast;
    active    = activeQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                       activeQ <= 1'b0;
    else if (startStb)               activeQ <= 1'b1;
    else if (stopStb)                activeQ <= 1'b0;
    else if (activeQ && beatIsLast)  activeQ <= 1'b0;
  end

  AST_START_BEGINS: assert property (@(posedge clk) disable iff (!rstN)
    startStb |=> activeQ); // R8

  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    stopStb && !startStb |=> !activeQ); // R7

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    activeQ && beatIsLast && !startStb |=> !activeQ); // R6
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startStb,
  input  logic [COL_W-1:0] startCol,
  input  logic             isWrite,
  input  logic             stopStb,
  input  logic [LEN_W-1:0] modeLen,
  input  logic             modeInterleave,
  input  logic             modeSingleWrite,
  output logic [COL_W-1:0] colOut,
  output logic             colValid,
  output logic             lastBeat
);
  bcgStrobe_t strb;
  logic       active, beatIsLast;

  bcg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startStb(startStb), .stopStb(stopStb),
    .beatIsLast(beatIsLast), .strb(strb), .active(active)
  );

  bcg_datapath #(.COL_W(COL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .startCol(startCol),
    .isWrite(isWrite), .modeLen(modeLen), .modeInterleave(modeInterleave),
    .modeSingleWrite(modeSingleWrite), .colOut(colOut), .beatIsLast(beatIsLast)
  );

  assign colValid = active;
  assign lastBeat = active && beatIsLast;

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    !rstN |=> !colValid && !lastBeat); // R1
endmodule

// File: tb/sim_burst_col_gen.sv
`timescale 1ns/1ps
module sim_burst_col_gen;
  logic       clk = 1'b0;
  logic       rstN, startStb, isWrite, stopStb, modeInterleave, modeSingleWrite;
  logic [7:0] startCol;
  logic [2:0] modeLen;
  logic [7:0] colOut;
  logic       colValid, lastBeat;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  burst_col_gen u0 (
    .clk(clk), .rstN(rstN), .startStb(startStb), .startCol(startCol),
    .isWrite(isWrite), .stopStb(stopStb), .modeLen(modeLen),
    .modeInterleave(modeInterleave), .modeSingleWrite(modeSingleWrite),
    .colOut(colOut), .colValid(colValid), .lastBeat(lastBeat)
  );

  function automatic int lenOf(input logic [2:0] code, input logic w, input logic sw);
    if (w && sw) return 1;
    case (code)
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      3'b111: return 0;   // full page
      default: return 1;
    endcase
  endfunction

  function automatic logic [7:0] expCol(input logic [7:0] s, input int k,
                                        input int len, input logic il);
    logic [7:0] m, low;
    if (len == 0) return 8'(int'(s) + k);
    m   = 8'(len - 1);
    low = il ? (s ^ 8'(k)) : 8'(int'(s) + k);
    return (s & ~m) | (low & m);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic scramble();
    modeLen = 3'($urandom); modeInterleave = 1'($urandom);
    modeSingleWrite = 1'($urandom); isWrite = 1'($urandom);
    startCol = 8'($urandom);
  endtask

  // one burst; stopAt < 0 means no stop
  task automatic burst(input logic [7:0] s, input logic w, input logic [2:0] code,
                       input logic il, input logic sw, input int stopAt);
    int  len = lenOf(code, w, sw);
    bit  done = 0;
    int  k = 0;
    @(negedge clk);
    startStb = 1; startCol = s; isWrite = w; modeLen = code;
    modeInterleave = il; modeSingleWrite = sw;
    @(negedge clk);
    startStb = 0;
    while (!done) begin
      chk("R2 valid", colValid, 1);
      if (len == 0)      chk("R5 col", colOut, expCol(s, k, 0, 0));
      else if (il)       chk("R4 col", colOut, expCol(s, k, len, 1));
      else               chk("R3 col", colOut, expCol(s, k, len, 0));
      chk(len == 0 ? "R5 last" : "R6 last", lastBeat, (len != 0 && k == len - 1));
      scramble();  // R10: must not disturb the running burst
      if (k == stopAt) begin stopStb = 1; done = 1; end
      if (len != 0 && k == len - 1) done = 1;
      @(negedge clk);
      stopStb = 0;
      k++;
    end
    chk(stopAt >= 0 ? "R7 end" : "R6 end", colValid, 0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    rstN = 0; startStb = 0; stopStb = 0; isWrite = 0; startCol = 0;
    modeLen = 0; modeInterleave = 0; modeSingleWrite = 0;
    repeat (3) @(negedge clk);
    chk("R1 valid", colValid, 0); chk("R1 last", lastBeat, 0);
    rstN = 1;
    @(negedge clk);
    chk("R1 valid idle", colValid, 0); chk("R1 last idle", lastBeat, 0);

    // directed corners
    burst(8'h07, 0, 3'b011, 0, 0, -1);  // R3 wrap 7 -> 0 in block
    burst(8'hFE, 0, 3'b010, 0, 0, -1);  // R3 upper bits fixed
    burst(8'h5B, 0, 3'b011, 1, 0, -1);  // R4 interleave
    burst(8'hFA, 0, 3'b111, 1, 0, 12);  // R5 wrap 255 -> 0, ignores interleave
    burst(8'h10, 1, 3'b011, 0, 1, -1);  // R9 single write
    burst(8'h10, 0, 3'b011, 0, 1, -1);  // R9 read keeps length
    burst(8'h33, 0, 3'b101, 0, 0, -1);  // R2 reserved code -> 1
    burst(8'h40, 0, 3'b011, 0, 0, 2);   // R7 stop mid burst
    burst(8'h00, 0, 3'b111, 0, 0, 300); // R5 long full page

    // R8 back-to-back starts and start with stop
    @(negedge clk);
    startStb = 1; startCol = 8'h20; modeLen = 3'b011; modeInterleave = 0;
    isWrite = 0; modeSingleWrite = 0;
    @(negedge clk);
    chk("R8 first", colOut, 8'h20);
    startCol = 8'h85; stopStb = 1;
    @(negedge clk);
    startStb = 0; stopStb = 0;
    chk("R8 restart valid", colValid, 1);
    chk("R8 restart col", colOut, 8'h85);
    @(negedge clk);
    chk("R8 restart beat1", colOut, 8'h86);
    stopStb = 1;
    @(negedge clk);
    stopStb = 0;
    chk("R7 after stop", colValid, 0);

    // constrained random
    for (int n = 0; n < 300; n++) begin
      logic [2:0] c = 3'($urandom);
      int sa = ($urandom % 4 == 0) ? int'($urandom % 10) : -1;
      if (c == 3'b111 && sa < 0) sa = int'($urandom % 300);
      burst(8'($urandom), 1'($urandom), c, 1'($urandom), 1'($urandom), sa);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule